// File: doc/BRIEF.md
# Serial Programming Target Responder

This block stands in for a programmable device on the slave side of a four-byte serial programming link. A host drives a serial clock and a data line in. The block shifts in one instruction per frame and returns bytes on its data-out line. It keeps a one-page word buffer, a small flash array of several pages and a byte-wide EEPROM array, all held in registers. It carries out the enable, page-load, page-write, read and EEPROM-write instructions.

The serial lines are sampled with the block's own system clock through synchronisers, so the host clock must be several times slower than `clk_i`. A write starts a busy interval counted in system cycles. While it runs, reads of the affected page or byte return 0xFF and every other instruction is dropped. This lets a host poll for the end of a write by reading back.

Top module: `spt_responder`

## Requirements
- R1: The data-in line is sampled on the rising serial-clock edge, MSB first. The data-out line changes only after a falling serial-clock edge. Data-out is low after `rst_ni` and while `prog_rst_i` is high.
- R2: A frame with bytes 0xAC, 0x53 in first and second place turns programming on, provided `prog_rst_i` is low. Until then every other instruction is ignored and reads return 0x00. Raising `prog_rst_i` turns programming off.
- R3: In every frame, the second received byte is sent back on data-out during the third byte-time.
- R4: Frames are always four bytes long. A frame that is out of step has no effect. A pulse on `prog_rst_i` clears the bit and byte counters, so the next bit starts a new frame.
- R5: Opcode 0x40 stores data byte 4 as the low byte, and 0x48 as the high byte, of buffer word `byte3[PAGE_LG-1:0]`.
- R6: Opcode 0x4C writes the whole buffer at once into the page selected by the upper word-address bits. The word address is formed from bytes 2 and 3 (byte 3 is its low part), and the upper bits start at bit PAGE_LG. Words that were not loaded become 0xFF, the buffer refills with 0xFF, and other pages keep their contents.
- R7: Opcode 0x20 (low byte) or 0x28 (high byte) returns the flash word at the address in bytes 2 and 3 during the fourth byte-time. The array starts at 0xFF.
- R8: For FLASH_BUSY_CYC cycles after a page write, a read of any word in that page returns 0xFF.
- R9: Opcode 0xC0 writes data byte 4 to EEPROM address `byte3[EE_AW-1:0]`. The old content is replaced, not combined, so bits can go from 0 to 1.
- R10: Opcode 0xA0 returns the EEPROM byte during the fourth byte-time. The array starts at 0xFF, and a byte under write reads 0xFF for EE_BUSY_CYC cycles.
- R11: While either write interval runs, only reads are acted on. Loads and writes are dropped.
- R12: Any other first byte is discarded without side effects. Outside the echo and read-data byte-times, data-out returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the host |
| mosi_i | input | 1 | Serial data from the host |
| prog_rst_i | input | 1 | Target reset line, high to leave programming and realign |
| miso_o | output | 1 | Serial data to the host |

## Verification
The bench polls a page it has just written and a byte it has just written, and expects 0xFF. A design that shows new data early, or masks the wrong page, returns the stored value instead. It issues an EEPROM write during a flash write, and a rewrite that sets bits back to 1. A design that is not exclusive, or that ANDs instead of erasing, leaves a wrong byte. It writes a second page after the first and reads back an unloaded high byte, which shows whether the buffer refills. It injects three stray bits and checks that the echo is lost and that a pulse on the reset line brings it back.

// File: rtl/spt_pkg.sv
package spt_pkg;
  localparam int unsigned FRAME_BYTES = 4;
  localparam int unsigned IDX_W       = $clog2(FRAME_BYTES);

  localparam logic [7:0] OP_ENABLE  = 8'hAC;
  localparam logic [7:0] EN_KEY     = 8'h53;
  localparam logic [7:0] OP_LD_LO   = 8'h40;
  localparam logic [7:0] OP_LD_HI   = 8'h48;
  localparam logic [7:0] OP_WR_PAGE = 8'h4C;
  localparam logic [7:0] OP_RD_LO   = 8'h20;
  localparam logic [7:0] OP_RD_HI   = 8'h28;
  localparam logic [7:0] OP_EE_RD   = 8'hA0;
  localparam logic [7:0] OP_EE_WR   = 8'hC0;
  localparam logic [7:0] ERASED     = 8'hFF;

  typedef enum logic [3:0] {
    CMD_NONE, CMD_ENABLE, CMD_LD_LO, CMD_LD_HI, CMD_WR_PAGE,
    CMD_RD_LO, CMD_RD_HI, CMD_EE_RD, CMD_EE_WR
  } cmd_e;

  function automatic cmd_e decode_cmd(input logic [7:0] op, input logic [7:0] arg);
    case (op)
      OP_ENABLE:  return (arg == EN_KEY) ? CMD_ENABLE : CMD_NONE;
      OP_LD_LO:   return CMD_LD_LO;
      OP_LD_HI:   return CMD_LD_HI;
      OP_WR_PAGE: return CMD_WR_PAGE;
      OP_RD_LO:   return CMD_RD_LO;
      OP_RD_HI:   return CMD_RD_HI;
      OP_EE_RD:   return CMD_EE_RD;
      OP_EE_WR:   return CMD_EE_WR;
      default:    return CMD_NONE;
    endcase
  endfunction
endpackage

// File: rtl/spt_link.sv
module spt_link
  import spt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             mosi_i,
  input  logic             prst_i,
  input  logic [7:0]       tx_byte_i,
  output logic             byte_done_o,
  output logic [IDX_W-1:0] byte_idx_o,
  output logic [7:0]       byte_val_o,
  output logic             prst_o,
  output logic             miso_o
);
  logic [2:0]       sck_q;   // [1:0] sync, [2] previous
  logic [1:0]       mosi_q;
  logic [1:0]       prst_q;
  logic [2:0]       bit_cnt;
  logic [IDX_W-1:0] byte_idx;
  logic [6:0]       rx_sr;
  logic [7:0]       tx_sr;
  logic             miso_q;
  logic             rise, fall;

  assign rise = sck_q[1] & ~sck_q[2];
  assign fall = ~sck_q[1] & sck_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q    <= '0;
      mosi_q   <= '0;
      prst_q   <= '0;
      bit_cnt  <= '0;
      byte_idx <= '0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      miso_q   <= 1'b0;
    end else begin
      sck_q  <= {sck_q[1:0], sck_i};
      mosi_q <= {mosi_q[0], mosi_i};
      prst_q <= {prst_q[0], prst_i};
      if (prst_q[1]) begin
        bit_cnt  <= '0;
        byte_idx <= '0;
        tx_sr    <= '0;
        miso_q   <= 1'b0;
      end else if (rise) begin
        rx_sr   <= {rx_sr[5:0], mosi_q[1]};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_idx <= byte_idx + 1'b1;
          tx_sr    <= tx_byte_i;
        end
      end else if (fall) begin
        miso_q <= tx_sr[7];
        tx_sr  <= {tx_sr[6:0], 1'b0};
      end
    end
  end

  assign byte_done_o = rise & (bit_cnt == 3'd7) & ~prst_q[1];
  assign byte_idx_o  = byte_idx;
  assign byte_val_o  = {rx_sr, mosi_q[1]};
  assign prst_o      = prst_q[1];
  assign miso_o      = miso_q;
endmodule

// File: rtl/spt_page_buf.sv
module spt_page_buf
  import spt_pkg::*;
#(
  parameter int unsigned PAGE_LG = 6,
  localparam int unsigned PW = 1 << PAGE_LG
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ld_i,
  input  logic                hi_i,
  input  logic [PAGE_LG-1:0]  off_i,
  input  logic [7:0]          data_i,
  input  logic                clr_i,
  output logic [PW-1:0][7:0]  lo_o,
  output logic [PW-1:0][7:0]  hi_o
);
  logic [PW-1:0][7:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= {PW{ERASED}};
      hi_q <= {PW{ERASED}};
    end else if (clr_i) begin
      lo_q <= {PW{ERASED}};
      hi_q <= {PW{ERASED}};
    end else if (ld_i) begin
      for (int i = 0; i < PW; i++) begin
        if (off_i == PAGE_LG'(i)) begin
          if (hi_i) hi_q[i] <= data_i;
          else      lo_q[i] <= data_i;
        end
      end
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/spt_flash.sv
module spt_flash
  import spt_pkg::*;
#(
  parameter int unsigned PAGE_LG  = 6,
  parameter int unsigned PSEL_W   = 2,
  parameter int unsigned BUSY_CYC = 2000,
  localparam int unsigned PW    = 1 << PAGE_LG,
  localparam int unsigned AW    = PAGE_LG + PSEL_W,
  localparam int unsigned WORDS = 1 << AW,
  localparam int unsigned CW    = $clog2(BUSY_CYC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               commit_i,
  input  logic [PSEL_W-1:0]  page_i,
  input  logic [PW-1:0][7:0] buf_lo_i,
  input  logic [PW-1:0][7:0] buf_hi_i,
  input  logic [AW-1:0]      rd_addr_i,
  input  logic               rd_hi_i,
  output logic [7:0]         rd_data_o,
  output logic               busy_o
);
  logic [7:0]        mem_lo [WORDS];
  logic [7:0]        mem_hi [WORDS];
  logic [CW-1:0]     cnt;
  logic [PSEL_W-1:0] busy_page;

  // whole page copied in one cycle; readers are masked until cnt expires
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) begin
        mem_lo[i] <= ERASED;
        mem_hi[i] <= ERASED;
      end
    end else if (commit_i) begin
      for (int i = 0; i < WORDS; i++) begin
        if (page_i == PSEL_W'(i >> PAGE_LG)) begin
          mem_lo[i] <= buf_lo_i[i % PW];
          mem_hi[i] <= buf_hi_i[i % PW];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt       <= '0;
      busy_page <= '0;
    end else if (commit_i) begin
      cnt       <= CW'(BUSY_CYC);
      busy_page <= page_i;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy_o    = (cnt != '0);
  assign rd_data_o = (busy_o && rd_addr_i[AW-1:PAGE_LG] == busy_page) ? ERASED :
                     rd_hi_i ? mem_hi[rd_addr_i] : mem_lo[rd_addr_i];
endmodule

// File: rtl/spt_eeprom.sv
module spt_eeprom
  import spt_pkg::*;
#(
  parameter int unsigned EE_AW    = 6,
  parameter int unsigned BUSY_CYC = 1200,
  localparam int unsigned BYTES = 1 << EE_AW,
  localparam int unsigned CW    = $clog2(BUSY_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [EE_AW-1:0] wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic [EE_AW-1:0] rd_addr_i,
  output logic [7:0]       rd_data_o,
  output logic             busy_o
);
  logic [7:0]       mem [BYTES];
  logic [CW-1:0]    cnt;
  logic [EE_AW-1:0] busy_addr;

  // erase-then-write collapses to a plain replace
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BYTES; i++) mem[i] <= ERASED;
    end else if (wr_i) begin
      mem[wr_addr_i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt       <= '0;
      busy_addr <= '0;
    end else if (wr_i) begin
      cnt       <= CW'(BUSY_CYC);
      busy_addr <= wr_addr_i;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy_o    = (cnt != '0);
  assign rd_data_o = (busy_o && rd_addr_i == busy_addr) ? ERASED : mem[rd_addr_i];
endmodule

// File: rtl/spt_responder.sv
module spt_responder
  import spt_pkg::*;
#(
  parameter int unsigned PAGE_LG        = 6,
  parameter int unsigned PSEL_W         = 2,
  parameter int unsigned EE_AW          = 6,
  parameter int unsigned FLASH_BUSY_CYC = 2000,
  parameter int unsigned EE_BUSY_CYC    = 1200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic prog_rst_i,
  output logic miso_o
);
  localparam int unsigned FAW = PAGE_LG + PSEL_W;
  localparam int unsigned PW  = 1 << PAGE_LG;

  logic             byte_done;
  logic [IDX_W-1:0] byte_idx;
  logic [7:0]       byte_val;
  logic [7:0]       tx_val;
  logic             prst_s;
  logic             prog_en;
  logic [7:0]       f0, f1, f2;
  cmd_e             cmd;
  logic             exec, idle_ok;
  logic             buf_ld, commit, ee_wr;
  logic             flash_busy, ee_busy;
  logic [7:0]       flash_rd, ee_rd;
  logic [FAW-1:0]   rd_faddr, ex_faddr;
  logic [EE_AW-1:0] rd_eaddr, ex_eaddr;
  logic [PW-1:0][7:0] buf_lo, buf_hi;

  spt_link u_link (
    .clk_i, .rst_ni, .sck_i, .mosi_i,
    .prst_i     (prog_rst_i),
    .tx_byte_i  (tx_val),
    .byte_done_o(byte_done),
    .byte_idx_o (byte_idx),
    .byte_val_o (byte_val),
    .prst_o     (prst_s),
    .miso_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f0 <= '0;
      f1 <= '0;
      f2 <= '0;
    end else if (byte_done) begin
      case (byte_idx)
        2'd0:    f0 <= byte_val;
        2'd1:    f1 <= byte_val;
        2'd2:    f2 <= byte_val;
        default: ;
      endcase
    end
  end

  assign cmd = decode_cmd(f0, f1);

  // read address uses the byte just completed, so data is ready for the fourth byte
  assign rd_faddr = FAW'({f1, byte_val});
  assign rd_eaddr = EE_AW'({f1, byte_val});
  assign ex_faddr = FAW'({f1, f2});
  assign ex_eaddr = EE_AW'({f1, f2});

  always_comb begin
    tx_val = 8'h00;
    case (byte_idx)
      2'd1: tx_val = byte_val;
      2'd2: if (prog_en) begin
        case (cmd)
          CMD_RD_LO, CMD_RD_HI: tx_val = flash_rd;
          CMD_EE_RD:            tx_val = ee_rd;
          default:              ;
        endcase
      end
      default: ;
    endcase
  end

  assign exec    = byte_done && (byte_idx == 2'd3);
  assign idle_ok = prog_en && !flash_busy && !ee_busy;
  assign buf_ld  = exec && idle_ok && (cmd == CMD_LD_LO || cmd == CMD_LD_HI);
  assign commit  = exec && idle_ok && (cmd == CMD_WR_PAGE);
  assign ee_wr   = exec && idle_ok && (cmd == CMD_EE_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           prog_en <= 1'b0;
    else if (prst_s)                       prog_en <= 1'b0;
    else if (exec && cmd == CMD_ENABLE)    prog_en <= 1'b1;
  end

  spt_page_buf #(.PAGE_LG(PAGE_LG)) u_buf (
    .clk_i, .rst_ni,
    .ld_i  (buf_ld),
    .hi_i  (cmd == CMD_LD_HI),
    .off_i (f2[PAGE_LG-1:0]),
    .data_i(byte_val),
    .clr_i (commit),
    .lo_o  (buf_lo),
    .hi_o  (buf_hi)
  );

  spt_flash #(
    .PAGE_LG(PAGE_LG), .PSEL_W(PSEL_W), .BUSY_CYC(FLASH_BUSY_CYC)
  ) u_flash (
    .clk_i, .rst_ni,
    .commit_i (commit),
    .page_i   (ex_faddr[FAW-1:PAGE_LG]),
    .buf_lo_i (buf_lo),
    .buf_hi_i (buf_hi),
    .rd_addr_i(rd_faddr),
    .rd_hi_i  (cmd == CMD_RD_HI),
    .rd_data_o(flash_rd),
    .busy_o   (flash_busy)
  );

  spt_eeprom #(.EE_AW(EE_AW), .BUSY_CYC(EE_BUSY_CYC)) u_ee (
    .clk_i, .rst_ni,
    .wr_i     (ee_wr),
    .wr_addr_i(ex_eaddr),
    .wr_data_i(byte_val),
    .rd_addr_i(rd_eaddr),
    .rd_data_o(ee_rd),
    .busy_o   (ee_busy)
  );
endmodule

// File: rtl/spt_responder_chk.sv
module spt_responder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       prst_s,
  input logic       prog_en,
  input logic       miso_o,
  input logic       byte_done,
  input logic [1:0] byte_idx,
  input logic       flash_busy,
  input logic       ee_busy
);
  // R1
  miso_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prst_s |=> !miso_o);
  // R2
  en_low_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_en) |-> $past(!prst_s));
  // R2
  rst_drops_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prst_s |=> !prog_en);
  // R2
  commit_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flash_busy) |-> prog_en);
  // R4
  realign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prst_s |=> (byte_idx == 2'd0));
  // R4
  frame_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done |=> (byte_idx == $past(byte_idx) + 2'd1));
  // R11
  flash_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flash_busy) |-> !$past(ee_busy));
  // R11
  ee_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ee_busy) |-> !$past(flash_busy));
endmodule

bind spt_responder spt_responder_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .prst_s    (prst_s),
  .prog_en   (prog_en),
  .miso_o    (miso_o),
  .byte_done (byte_done),
  .byte_idx  (byte_idx),
  .flash_busy(flash_busy),
  .ee_busy   (ee_busy)
);

// File: tb/tb_spt_responder.sv
module tb_spt_responder;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int N_VEC      = 29;

  // {b0, b1, b2, b3, expected 4th reply, requirement (0 = no 4th-byte check), wait cycles}
  localparam logic [63:0] VEC [N_VEC] = '{
    {8'hAC, 8'h53, 8'h00, 8'h00, 8'h00, 8'd12, 16'd0},    // R2 enable, R12 zero reply
    {8'h20, 8'h00, 8'h10, 8'h00, 8'hFF, 8'd7,  16'd0},    // R7 erased flash
    {8'hA0, 8'h00, 8'h07, 8'h00, 8'hFF, 8'd10, 16'd0},    // R10 erased eeprom
    {8'h40, 8'h00, 8'h05, 8'h34, 8'h00, 8'd12, 16'd0},    // R5 low byte
    {8'h48, 8'h00, 8'h05, 8'h12, 8'h00, 8'd12, 16'd0},    // R5 high byte
    {8'h40, 8'h00, 8'h3F, 8'hAB, 8'h00, 8'd12, 16'd0},    // R5 last word
    {8'h4C, 8'h00, 8'h40, 8'h00, 8'h00, 8'd12, 16'd0},    // R6 write page 1
    {8'h20, 8'h00, 8'h45, 8'h00, 8'hFF, 8'd8,  16'd0},    // R8 polled word busy
    {8'h28, 8'h00, 8'h7F, 8'h00, 8'hFF, 8'd8,  16'd0},    // R8 other word in page
    {8'hC0, 8'h00, 8'h07, 8'h5A, 8'h00, 8'd12, 16'd2500}, // R11 write while busy
    {8'hA0, 8'h00, 8'h07, 8'h00, 8'hFF, 8'd11, 16'd0},    // R11 dropped
    {8'h20, 8'h00, 8'h45, 8'h00, 8'h34, 8'd5,  16'd0},    // R5
    {8'h28, 8'h00, 8'h45, 8'h00, 8'h12, 8'd5,  16'd0},    // R5
    {8'h20, 8'h00, 8'h7F, 8'h00, 8'hAB, 8'd6,  16'd0},    // R6
    {8'h28, 8'h00, 8'h7F, 8'h00, 8'hFF, 8'd6,  16'd0},    // R6 unloaded half
    {8'h20, 8'h00, 8'h46, 8'h00, 8'hFF, 8'd6,  16'd0},    // R6 unloaded word
    {8'hC0, 8'h00, 8'h07, 8'hF0, 8'h00, 8'd12, 16'd0},    // R9
    {8'hA0, 8'h00, 8'h07, 8'h00, 8'hFF, 8'd10, 16'd1500}, // R10 busy byte
    {8'hA0, 8'h00, 8'h07, 8'h00, 8'hF0, 8'd9,  16'd0},    // R9
    {8'hC0, 8'h00, 8'h07, 8'h0F, 8'h00, 8'd12, 16'd1500}, // R9 rewrite
    {8'hA0, 8'h00, 8'h07, 8'h00, 8'h0F, 8'd9,  16'd0},    // R9 replaced, not ANDed
    {8'h55, 8'h11, 8'h22, 8'h33, 8'h00, 8'd12, 16'd0},    // R12 unknown opcode
    {8'hA0, 8'h00, 8'h07, 8'h00, 8'h0F, 8'd12, 16'd0},    // R12 no side effect
    {8'h40, 8'h00, 8'h85, 8'h66, 8'h00, 8'd12, 16'd0},    // R5
    {8'h4C, 8'h00, 8'h80, 8'h00, 8'h00, 8'd12, 16'd2500}, // R6 page 2
    {8'h20, 8'h00, 8'h85, 8'h00, 8'h66, 8'd6,  16'd0},    // R6
    {8'h28, 8'h00, 8'h85, 8'h00, 8'hFF, 8'd6,  16'd0},    // R6 buffer refilled
    {8'h20, 8'h00, 8'h45, 8'h00, 8'h34, 8'd6,  16'd0},    // R6 other page intact
    {8'hA0, 8'h00, 8'h08, 8'h00, 8'hFF, 8'd10, 16'd0}     // R10
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic prog_rst = 1'b0;
  logic miso;
  int   n_tests = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spt_responder dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .sck_i     (sck),
    .mosi_i    (mosi),
    .prog_rst_i(prog_rst),
    .miso_o    (miso)
  );

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic frame(input logic [7:0] b0, b1, b2, b3,
                       output logic [7:0] r2, output logic [7:0] r3);
    logic [7:0] junk;
    xfer_byte(b0, junk);
    xfer_byte(b1, junk);
    xfer_byte(b2, r2);
    xfer_byte(b3, r3);
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_prst();
    prog_rst = 1'b1;
    repeat (8) @(negedge clk);
    prog_rst = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r2, r3;
    repeat (5) @(negedge clk);
    check(1, {7'd0, miso}, 8'h00);   // R1 reset state
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    for (int v = 0; v < N_VEC; v++) begin
      frame(VEC[v][63:56], VEC[v][55:48], VEC[v][47:40], VEC[v][39:32], r2, r3);
      check(3, r2, VEC[v][55:48]);   // R3 echo every frame
      if (VEC[v][23:16] != 8'd0) check(int'(VEC[v][23:16]), r3, VEC[v][31:24]);
      repeat (int'(VEC[v][15:0])) @(negedge clk);
    end

    // R2: reset line drops programming; writes ignored, reads give zero
    pulse_prst();
    frame(8'hC0, 8'h00, 8'h09, 8'h44, r2, r3);
    repeat (1500) @(negedge clk);
    frame(8'hA0, 8'h00, 8'h09, 8'h00, r2, r3);
    check(2, r3, 8'h00);
    frame(8'hAC, 8'h53, 8'h00, 8'h00, r2, r3);
    frame(8'hA0, 8'h00, 8'h09, 8'h00, r2, r3);
    check(2, r3, 8'hFF);

    // R2 and R1: enable sent while reset line is high is not taken, data-out stays low
    prog_rst = 1'b1;
    repeat (8) @(negedge clk);
    frame(8'hAC, 8'h53, 8'h00, 8'h00, r2, r3);
    check(1, r2, 8'h00);
    check(1, r3, 8'h00);
    prog_rst = 1'b0;
    repeat (8) @(negedge clk);
    frame(8'hC0, 8'h00, 8'h0A, 8'h11, r2, r3);
    repeat (1500) @(negedge clk);
    frame(8'hAC, 8'h53, 8'h00, 8'h00, r2, r3);
    frame(8'hA0, 8'h00, 8'h0A, 8'h00, r2, r3);
    check(2, r3, 8'hFF);

    // R4: three stray bits put frames out of step
    pulse_prst();
    for (int i = 0; i < 3; i++) begin
      mosi = 1'b0;
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    frame(8'hAC, 8'h53, 8'h00, 8'h00, r2, r3);
    n_tests++;
    if (r2 === 8'h53) begin
      n_fail++;
      $display("FAIL R4: got %02h expected not 53", r2);
    end
    frame(8'hC0, 8'h00, 8'h0B, 8'h22, r2, r3);
    repeat (1500) @(negedge clk);
    pulse_prst();
    frame(8'hAC, 8'h53, 8'h00, 8'h00, r2, r3);
    check(4, r2, 8'h53);             // R4 realigned
    frame(8'hA0, 8'h00, 8'h0B, 8'h00, r2, r3);
    check(4, r3, 8'hFF);             // R4 misaligned write had no effect

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule